// File: doc/BRIEF.md
# Configuration Packet Assembler and Router

This block takes 32-bit words written into a keyhole window and collects them into 128-bit configuration packets. The address of each write picks one of four word slots. A write to the highest slot completes a packet. The block then decodes the header word and forwards the packet on one or more of a set of row output ports. Each port carries a one-cycle valid pulse, a 6-bit target register address and the full 128-bit packet. One reserved row code sends the packet to every row that exists.

A special packet opens a counted burst. A packet of the unit type that addresses the frame-data register loads a burst count from its second word and remembers its row. While that count is nonzero, each completed packet goes to the remembered row as frame data and its header is not decoded. An error pulse is raised when the loaded count is not a multiple of the frame size. A decompress-enable input drops every completed packet.

Top module: `cfg_pkt_router`

## Requirements
- R1: A write stores its data in the slot given by address bits [3:2]. The other address bits have no effect. Slots may be written in any order, and a repeated write to a slot replaces the earlier word.
- R2: A write to slot 3 completes a packet with word0..word3 in slots 0..3. All slots are then cleared to zero, so a slot that is not rewritten contributes zero to the next packet.
- R3: The header is word0: type in bits [31:24], row in bits [20:16], register address in bits [13:8]. A packet of the frame type is sent to its row with its own register address. The addressed port pulses valid for exactly one cycle, in the cycle after the completing write, with data = {word3, word2, word1, word0} (word0 in bits [31:0]).
- R4: Row code 31 (0x1F) sends the packet to all present rows at once. Rows from NUM_ROWS to 30 reach no port.
- R5: A row whose bit in the ROW_PRESENT mask is 0 never pulses valid.
- R6: A packet of the unit type whose register address equals FDATA_REG loads the burst count from word1 and latches the header row. The packet itself produces no output.
- R7: In the cycle after such a load, the error output pulses high for one cycle if the loaded count is not a multiple of BURST_MOD (25). It stays low for counts that are multiples, including zero.
- R8: While the burst count is nonzero, every completed packet goes to the latched row with register address FDATA_REG, whatever its header says, and the count drops by one. At zero, header decoding resumes. A latched row of 31 broadcasts.
- R9: While decompress-enable is high, completed packets produce no output, load nothing, and leave the burst count unchanged.
- R10: Packets of any other type, and unit-type packets with a different register address, produce no output and no load.
- R11: A synchronous reset clears the slots, the burst count, the latched row, all valid outputs and the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the keyhole window |
| wr_addr | input | ADDR_W | Byte address of the write within the window |
| wr_data | input | 32 | Write data |
| decomp_en | input | 1 | Drop completed packets while high |
| row_valid | output | NUM_ROWS | Per-row one-cycle packet strobe |
| row_reg | output | NUM_ROWS x 6 | Per-row target register address |
| row_data | output | NUM_ROWS x 128 | Per-row packet data |
| cnt_err | output | 1 | Pulse: loaded burst count not a multiple of BURST_MOD |

## Verification
The bench builds the block with 15 rows and a presence mask that leaves row 4 out. It sets the frame type code to 0x00 and the unit type code to 0x01, so a packet whose word0 was never written is a frame packet to row 0. That makes slot clearing after a packet and after reset visible at the ports. With FDATA_REG = 2, the bench sweeps every one of the 32 row codes and runs bursts of 3, 25 and 50 packets aimed at a single row, at the broadcast code and at a row that does not exist. It also checks that decompress mode leaves a burst untouched.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int WORD_W = 32;
  localparam int SLOTS  = 4;
  localparam int PKT_W  = WORD_W * SLOTS;
  localparam int REG_W  = 6;
  localparam int ROW_W  = 5;

  function automatic logic [7:0] hdr_type(input logic [WORD_W-1:0] w);
    return w[31:24];
  endfunction

  function automatic logic [ROW_W-1:0] hdr_row(input logic [WORD_W-1:0] w);
    return w[20:16];
  endfunction

  function automatic logic [REG_W-1:0] hdr_reg(input logic [WORD_W-1:0] w);
    return w[13:8];
  endfunction

  // a loaded count is acceptable when it is a whole number of frames
  function automatic logic cnt_ok(input logic [WORD_W-1:0] cnt, input int unsigned modv);
    return (cnt % WORD_W'(modv)) == '0;
  endfunction

  // one-hot row select, all ones for the broadcast code, zero for absent codes
  function automatic logic [31:0] route_mask(input logic [ROW_W-1:0] row,
                                             input logic [ROW_W-1:0] bcast,
                                             input int unsigned nrows);
    if (row == bcast)        return '1;
    else if (32'(row) < nrows) return 32'd1 << row;
    else                     return '0;
  endfunction
endpackage

// File: rtl/cfgr_slot_fifo.sv
module cfgr_slot_fifo
  import cfgr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pkt_done,
  output logic [PKT_W-1:0]  pkt_words
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LAST   = SLOTS - 1;

  logic [SLOT_W-1:0] slot_idx;
  logic              unused_addr_bits;
  logic [LAST-1:0][WORD_W-1:0] held;

  assign slot_idx         = wr_addr[2 +: SLOT_W];
  assign unused_addr_bits = ^{wr_addr[ADDR_W-1:2+SLOT_W], wr_addr[1:0]};
  assign pkt_done         = wr_en && (slot_idx == SLOT_W'(LAST));

  // the last slot is never stored: its word completes the packet directly
  for (genvar i = 0; i < LAST; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || pkt_done)
        held[i] <= '0;
      else if (wr_en && slot_idx == SLOT_W'(i))
        held[i] <= wr_data;
    end
    assign pkt_words[i*WORD_W +: WORD_W] = held[i];
  end
  assign pkt_words[LAST*WORD_W +: WORD_W] = wr_data;
endmodule

// File: rtl/cfgr_dispatch.sv
module cfgr_dispatch
  import cfgr_pkg::*;
#(
  parameter logic [7:0]       TYPE_UNIT  = 8'h00,
  parameter logic [7:0]       TYPE_FRAME = 8'h01,
  parameter logic [REG_W-1:0] FDATA_REG  = 6'h02,
  parameter int unsigned      BURST_MOD  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_done,
  input  logic [PKT_W-1:0]  pkt_words,
  input  logic              decomp_en,
  output logic              fire,
  output logic [ROW_W-1:0]  tgt_row,
  output logic [REG_W-1:0]  tgt_reg,
  output logic              load_evt,
  output logic [WORD_W-1:0] burst_cnt,
  output logic              cnt_err
);
  logic [WORD_W-1:0] w0, w1;
  logic [ROW_W-1:0]  lat_row;
  logic              accept, in_burst;

  assign w0       = pkt_words[0 +: WORD_W];
  assign w1       = pkt_words[WORD_W +: WORD_W];
  assign accept   = pkt_done && !decomp_en;
  assign in_burst = burst_cnt != '0;
  assign load_evt = accept && !in_burst && hdr_type(w0) == TYPE_UNIT
                    && hdr_reg(w0) == FDATA_REG;

  always_comb begin
    fire    = 1'b0;
    tgt_row = hdr_row(w0);
    tgt_reg = hdr_reg(w0);
    if (accept && in_burst) begin
      fire    = 1'b1;
      tgt_row = lat_row;
      tgt_reg = FDATA_REG;
    end else if (accept && hdr_type(w0) == TYPE_FRAME) begin
      fire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_cnt <= '0;
      lat_row   <= '0;
      cnt_err   <= 1'b0;
    end else begin
      cnt_err <= load_evt && !cnt_ok(w1, BURST_MOD);
      if (load_evt) begin
        burst_cnt <= w1;
        lat_row   <= hdr_row(w0);
      end else if (accept && in_burst) begin
        burst_cnt <= burst_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgr_row_bank.sv
module cfgr_row_bank
  import cfgr_pkg::*;
#(
  parameter int NUM_ROWS = 15
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_ROWS-1:0]                sel,
  input  logic [REG_W-1:0]                   reg_in,
  input  logic [PKT_W-1:0]                   data_in,
  output logic [NUM_ROWS-1:0]                row_valid,
  output logic [NUM_ROWS-1:0][REG_W-1:0]     row_reg,
  output logic [NUM_ROWS-1:0][PKT_W-1:0]     row_data
);
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        row_valid[r] <= 1'b0;
        row_reg[r]   <= '0;
        row_data[r]  <= '0;
      end else begin
        row_valid[r] <= sel[r];
        if (sel[r]) begin
          row_reg[r]  <= reg_in;
          row_data[r] <= data_in;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_router.sv
module cfg_pkt_router
  import cfgr_pkg::*;
#(
  parameter int                    NUM_ROWS    = 15,
  parameter int                    ADDR_W      = 12,
  parameter logic [NUM_ROWS-1:0]   ROW_PRESENT = '1,
  parameter logic [ROW_W-1:0]      BCAST_ROW   = 5'h1F,
  parameter logic [7:0]            TYPE_UNIT   = 8'h00,
  parameter logic [7:0]            TYPE_FRAME  = 8'h01,
  parameter logic [REG_W-1:0]      FDATA_REG   = 6'h02,
  parameter int unsigned           BURST_MOD   = 25
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [WORD_W-1:0]              wr_data,
  input  logic                           decomp_en,
  output logic [NUM_ROWS-1:0]            row_valid,
  output logic [NUM_ROWS-1:0][REG_W-1:0] row_reg,
  output logic [NUM_ROWS-1:0][PKT_W-1:0] row_data,
  output logic                           cnt_err
);
  logic              pkt_done;
  logic [PKT_W-1:0]  pkt_words;
  logic              fire;
  logic [ROW_W-1:0]  tgt_row;
  logic [REG_W-1:0]  tgt_reg;
  logic              load_evt;
  logic [WORD_W-1:0] burst_cnt;
  logic [31:0]       raw_mask;
  logic [NUM_ROWS-1:0] row_sel;
  logic              unused_mask_bits;

  cfgr_slot_fifo #(.ADDR_W(ADDR_W)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pkt_done(pkt_done), .pkt_words(pkt_words)
  );

  cfgr_dispatch #(
    .TYPE_UNIT(TYPE_UNIT), .TYPE_FRAME(TYPE_FRAME),
    .FDATA_REG(FDATA_REG), .BURST_MOD(BURST_MOD)
  ) disp_i (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_words(pkt_words),
    .decomp_en(decomp_en), .fire(fire), .tgt_row(tgt_row), .tgt_reg(tgt_reg),
    .load_evt(load_evt), .burst_cnt(burst_cnt), .cnt_err(cnt_err)
  );

  assign raw_mask         = route_mask(tgt_row, BCAST_ROW, NUM_ROWS);
  assign row_sel          = raw_mask[NUM_ROWS-1:0] & ROW_PRESENT & {NUM_ROWS{fire}};
  assign unused_mask_bits = ^raw_mask;

  cfgr_row_bank #(.NUM_ROWS(NUM_ROWS)) bank_i (
    .clk(clk), .rst(rst), .sel(row_sel), .reg_in(tgt_reg), .data_in(pkt_words),
    .row_valid(row_valid), .row_reg(row_reg), .row_data(row_data)
  );
endmodule

// File: rtl/cfg_pkt_router_chk.sv
module cfg_pkt_router_chk
  import cfgr_pkg::*;
#(
  parameter int                  NUM_ROWS    = 15,
  parameter logic [NUM_ROWS-1:0] ROW_PRESENT = '1,
  parameter logic [REG_W-1:0]    FDATA_REG   = 6'h02
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           decomp_en,
  input logic                           pkt_done,
  input logic                           load_evt,
  input logic [WORD_W-1:0]              burst_cnt,
  input logic [NUM_ROWS-1:0]            row_valid,
  input logic [NUM_ROWS-1:0][REG_W-1:0] row_reg,
  input logic                           cnt_err
);
  // R3
  valid_follows_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid != '0) |-> $past(pkt_done));

  // R5
  absent_row_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (row_valid & ~ROW_PRESENT) == '0);

  // R7
  err_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_err |-> $past(load_evt));

  // R8
  burst_decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && !decomp_en && burst_cnt != '0) |=> burst_cnt == $past(burst_cnt) - 1);

  // R8
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_burst_reg
    burst_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (pkt_done && !decomp_en && burst_cnt != '0) |=> (!row_valid[r] || row_reg[r] == FDATA_REG));
  end

  // R9
  decomp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && decomp_en) |=> (row_valid == '0 && !cnt_err));

  // R9
  decomp_hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && decomp_en) |=> $stable(burst_cnt));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (row_valid == '0 && !cnt_err && burst_cnt == '0));
endmodule

bind cfg_pkt_router cfg_pkt_router_chk #(
  .NUM_ROWS(NUM_ROWS), .ROW_PRESENT(ROW_PRESENT), .FDATA_REG(FDATA_REG)
) chk_i (
  .clk(clk), .rst(rst), .decomp_en(decomp_en), .pkt_done(pkt_done),
  .load_evt(load_evt), .burst_cnt(burst_cnt), .row_valid(row_valid),
  .row_reg(row_reg), .cnt_err(cnt_err)
);

// File: tb/cfg_pkt_router_tb_top.sv
`timescale 1ns/1ps
module cfg_pkt_router_tb_top;
  localparam int          NR    = 15;
  localparam logic [14:0] PRES  = 15'h7FEF;
  localparam logic [7:0]  T_UNIT  = 8'h01;
  localparam logic [7:0]  T_FRAME = 8'h00;
  localparam logic [5:0]  FDR   = 6'h02;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic decomp_en = 1'b0;
  logic [NR-1:0] row_valid;
  logic [NR-1:0][5:0] row_reg;
  logic [NR-1:0][127:0] row_data;
  logic cnt_err;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_cnt = '0;
  logic [4:0]  m_row = '0;

  always #2 clk = ~clk;

  cfg_pkt_router #(
    .NUM_ROWS(NR), .ADDR_W(12), .ROW_PRESENT(PRES), .BCAST_ROW(5'h1F),
    .TYPE_UNIT(T_UNIT), .TYPE_FRAME(T_FRAME), .FDATA_REG(FDR), .BURST_MOD(25)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .decomp_en(decomp_en), .row_valid(row_valid), .row_reg(row_reg),
    .row_data(row_data), .cnt_err(cnt_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] t, input logic [4:0] r, input logic [5:0] g);
    return {t, 3'b101, r, 2'b10, g, 8'h3C};
  endfunction

  function automatic logic [NR-1:0] route(input logic [4:0] r);
    if (r == 5'h1F) return PRES;
    if (r < 5'(NR)) return (NR'(1) << r) & PRES;
    return '0;
  endfunction

  task automatic wr(input int slot, input logic [31:0] d, input logic [11:0] base);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = base | 12'(slot << 2); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // applies the requirement model to a completed packet and checks the ports
  task automatic judge(input logic [31:0] w0, w1, w2, w3, input string tag);
    logic [NR-1:0] em = '0;
    logic [5:0] eg = '0;
    logic ee = 1'b0;
    logic [127:0] ed = {w3, w2, w1, w0};
    if (!decomp_en) begin
      if (m_cnt != 0) begin
        em = route(m_row); eg = FDR; m_cnt = m_cnt - 1;
      end else if (w0[31:24] == T_FRAME) begin
        em = route(w0[20:16]); eg = w0[13:8];
      end else if (w0[31:24] == T_UNIT && w0[13:8] == FDR) begin
        m_cnt = w1; m_row = w0[20:16]; ee = (w1 % 25) != 0;
      end
    end
    chk(row_valid == em, {tag, " valid"}, 128'(row_valid), 128'(em));
    for (int r = 0; r < NR; r++) begin
      if (em[r] && row_valid[r]) begin
        chk(row_reg[r] == eg, {tag, " reg"}, 128'(row_reg[r]), 128'(eg));
        chk(row_data[r] == ed, {tag, " data"}, row_data[r], ed);
      end
    end
    chk(cnt_err == ee, {tag, " err"}, 128'(cnt_err), 128'(ee));
  endtask

  task automatic send(input logic [31:0] w0, w1, w2, w3, input logic [11:0] base, input string tag);
    wr(0, w0, base); wr(1, w1, base); wr(2, w2, base); wr(3, w3, base);
    judge(w0, w1, w2, w3, tag);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(row_valid == '0 && cnt_err == 1'b0, "R11 reset outputs", 128'({row_valid, cnt_err}), 128'(0));

    // R3 R4 R5 R1: sweep every row code, address upper bits vary
    for (int r = 0; r < 32; r++)
      send(hdr(T_FRAME, 5'(r), 6'(r ^ 21)), 32'h1000 + r, 32'h2000 + r, 32'h3000 + r,
           12'(r << 6), "R3 R4 R5 sweep");
    // R3 one-cycle pulse
    @(negedge clk);
    chk(row_valid == '0, "R3 pulse length", 128'(row_valid), 128'(0));

    // R1 out-of-order and overwrite
    wr(1, 32'hAAAA0001, 0); wr(0, hdr(T_FRAME, 5'd9, 6'h11), 12'h800);
    wr(2, 32'hDEAD0002, 0); wr(2, 32'hBEEF0002, 0);
    wr(0, hdr(T_FRAME, 5'd6, 6'h07), 0); wr(3, 32'h33333333, 12'h403);
    judge(hdr(T_FRAME, 5'd6, 6'h07), 32'hAAAA0001, 32'hBEEF0002, 32'h33333333, "R1 order overwrite");

    // R2 slots cleared after packet: frame type is 0x00, so zero header goes to row 0 reg 0
    wr(3, 32'h0000CAFE, 0);
    judge(32'h0, 32'h0, 32'h0, 32'h0000CAFE, "R2 cleared slots");

    // R10 other types and other unit registers dropped
    send(hdr(8'h7F, 5'd3, 6'h05), 1, 2, 3, 0, "R10 unknown type");
    send(hdr(T_UNIT, 5'd3, 6'h05), 25, 2, 3, 0, "R10 unit other reg");
    send(hdr(T_FRAME, 5'd3, 6'h05), 1, 2, 3, 0, "R10 follow-up decoded");

    // R6 R7 R8 burst of 3 to row 5 (not a multiple: error)
    send(hdr(T_UNIT, 5'd5, FDR), 3, 0, 0, 0, "R6 R7 load 3");
    for (int k = 0; k < 3; k++)
      send(hdr(8'(k * 40), 5'(k * 7), 6'(k + 30)), 32'(k), 32'h55, 32'h66, 0, "R8 burst row5");
    send(hdr(T_FRAME, 5'd8, 6'h0C), 7, 8, 9, 0, "R8 decode resumes");

    // R7 R8 25 to broadcast: no error
    send(hdr(T_UNIT, 5'h1F, FDR), 25, 0, 0, 0, "R7 load 25");
    for (int k = 0; k < 25; k++)
      send(hdr(T_FRAME, 5'd2, 6'h01), 32'(k), 32'(k * 3), 32'(k * 5), 0, "R8 burst broadcast");

    // R7 R8 50 to a row code with no port
    send(hdr(T_UNIT, 5'd20, FDR), 50, 0, 0, 0, "R7 load 50");
    for (int k = 0; k < 50; k++)
      send(hdr(T_FRAME, 5'd1, 6'h01), 32'(k), 0, 0, 0, "R8 burst absent row");
    send(hdr(T_FRAME, 5'd1, 6'h01), 4, 4, 4, 0, "R8 after absent burst");

    // R7 zero count: no error, no burst
    send(hdr(T_UNIT, 5'd2, FDR), 0, 0, 0, 0, "R7 load 0");
    send(hdr(T_FRAME, 5'd11, 6'h3F), 1, 1, 1, 0, "R6 zero count decodes");

    // R9 decompress during burst and for a load
    send(hdr(T_UNIT, 5'd3, FDR), 2, 0, 0, 0, "R9 load 2");
    decomp_en = 1'b1;
    send(hdr(T_FRAME, 5'd0, 6'h01), 9, 9, 9, 0, "R9 dropped in burst");
    send(hdr(T_UNIT, 5'd7, FDR), 26, 0, 0, 0, "R9 load ignored");
    decomp_en = 1'b0;
    for (int k = 0; k < 3; k++)
      send(hdr(T_FRAME, 5'd12, 6'h09), 32'(k), 0, 0, 0, "R9 burst kept");

    // R11 mid-run reset clears burst and slots
    send(hdr(T_UNIT, 5'd7, FDR), 5, 0, 0, 0, "R11 pre load");
    send(hdr(T_FRAME, 5'd0, 6'h01), 1, 0, 0, 0, "R11 pre burst");
    wr(0, 32'hFFFFFFFF, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_cnt = '0; m_row = '0;
    chk(row_valid == '0 && cnt_err == 1'b0, "R11 mid reset outputs", 128'({row_valid, cnt_err}), 128'(0));
    wr(3, 32'h0000BEAD, 0);
    judge(32'h0, 32'h0, 32'h0, 32'h0000BEAD, "R11 slots cleared");
    send(hdr(T_FRAME, 5'd13, 6'h2A), 1, 2, 3, 0, "R11 burst cleared");

    finish_run();
  end
endmodule